// File: doc/BRIEF.md
# Pad Ownership Router for GPIO and Two Peripherals

This block sits between a bank of pads and three possible pad users: the general-purpose I/O logic and two on-chip peripherals, called A and B. For every pin two control words from the port controller decide who owns the pad. The first is a per-pin GPIO-mode bit. The second is a per-pin peripheral choice bit. The block sends the pad level to the owner and drives the owner's output level and output enable onto the pad.

In GPIO mode both peripherals are cut off from the pin. In peripheral mode only the chosen peripheral sees the pad and drives it. The other peripheral's outputs are dropped, not merged, and its input for that pin reads 0. A pad that is being driven (its resulting output enable is high) does not loop its level back to any listener.

The router is combinational by default, so a change of either control word takes effect in the same cycle. A parameter can add a single register stage on every output for timing closure. That stage uses a synchronous, active-high reset.

Top module: `pin_mux`

## Requirements
- R1: In peripheral mode (`gpio_mode` bit = 0), a `sel_b` bit of 0 gives the pad's `pad_out`/`pad_oe` from peripheral A (`pa_out`/`pa_oe`), and a `sel_b` bit of 1 gives them from peripheral B (`pb_out`/`pb_oe`).
- R2: In peripheral mode with `pad_oe` low, `pad_in` is passed to `pa_in` when `sel_b` is 0, or to `pb_in` when `sel_b` is 1.
- R3: The output and output enable of the peripheral that is not chosen have no effect on `pad_out` or `pad_oe`.
- R4: When the `gpio_mode` bit is 1, `pad_out`/`pad_oe` come from `gpio_out`/`gpio_oe`, both peripherals' outputs have no effect, and `pa_in` and `pb_in` are 0 for that pin.
- R5: When a pin's resulting `pad_oe` is 1, `pa_in`, `pb_in` and `gpio_in` are all 0 for that pin.
- R6: The input of the peripheral that is not chosen is 0 for a pin in peripheral mode.
- R7: `gpio_in` equals `pad_in` when the `gpio_mode` bit is 1 and `pad_oe` is 0. Otherwise it is 0.
- R8: With `REG_OUT`=0 all outputs follow their inputs in the same cycle. With `REG_OUT`=1 every output shows the value for the inputs of the previous clock edge, and is 0 after a clock edge with `rst` high.
- R9: Each pin is routed independently of every other pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the optional output stage) |
| rst | input | 1 | Synchronous active-high reset |
| gpio_mode | input | NPIN | Per-pin GPIO ownership, 1 = GPIO |
| sel_b | input | NPIN | Per-pin peripheral choice, 0 = A, 1 = B |
| pad_in | input | NPIN | Level sampled at the pads |
| gpio_out | input | NPIN | GPIO output level |
| gpio_oe | input | NPIN | GPIO output enable |
| pa_out | input | NPIN | Peripheral A output level |
| pa_oe | input | NPIN | Peripheral A output enable |
| pb_out | input | NPIN | Peripheral B output level |
| pb_oe | input | NPIN | Peripheral B output enable |
| pad_out | output | NPIN | Level driven to the pads |
| pad_oe | output | NPIN | Output enable of the pads |
| gpio_in | output | NPIN | Pad level seen by GPIO |
| pa_in | output | NPIN | Pad level seen by peripheral A |
| pb_in | output | NPIN | Pad level seen by peripheral B |

## Verification
The bench builds two copies side by side at the full width of 32 pins. One uses `REG_OUT`=0 and the other uses `REG_OUT`=1, and both are fed the same stimulus. The combinational copy is checked in the cycle each vector is applied, so changes of select and mode word are seen taking effect at once. The registered copy is checked against the vector of the previous cycle, which covers the latency and the reset clearing of the stage. Full width lets the mixed-ownership patterns mix all three owners and both pad directions across one word.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  // Number of NPIN-wide output groups that leave the router
  localparam int OUT_GROUPS = 5;

  typedef enum logic [1:0] {
    OWN_GPIO = 2'd0,
    OWN_A    = 2'd1,
    OWN_B    = 2'd2
  } owner_e;

endpackage

// File: rtl/pinmux_owner_dec.sv
module pinmux_owner_dec #(
  parameter int NPIN = 32
) (
  input  logic [NPIN-1:0] gpio_mode,
  input  logic [NPIN-1:0] sel_b,
  output logic [NPIN-1:0] own_g,
  output logic [NPIN-1:0] own_a,
  output logic [NPIN-1:0] own_b
);
  import pinmux_pkg::*;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    owner_e owner;
    always_comb begin
      if (gpio_mode[i])  owner = OWN_GPIO;
      else if (sel_b[i]) owner = OWN_B;
      else               owner = OWN_A;
    end
    assign own_g[i] = (owner == OWN_GPIO);
    assign own_a[i] = (owner == OWN_A);
    assign own_b[i] = (owner == OWN_B);
  end

endmodule

// File: rtl/pinmux_out_sel.sv
module pinmux_out_sel #(
  parameter int NPIN = 32
) (
  input  logic [NPIN-1:0] own_g,
  input  logic [NPIN-1:0] own_a,
  input  logic [NPIN-1:0] own_b,
  input  logic [NPIN-1:0] gpio_out,
  input  logic [NPIN-1:0] gpio_oe,
  input  logic [NPIN-1:0] pa_out,
  input  logic [NPIN-1:0] pa_oe,
  input  logic [NPIN-1:0] pb_out,
  input  logic [NPIN-1:0] pb_oe,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe
);
  // AND-OR mux: owner vectors are one-hot per pin, so unchosen sources vanish
  always_comb begin
    pad_out = (own_g & gpio_out) | (own_a & pa_out) | (own_b & pb_out);
    pad_oe  = (own_g & gpio_oe)  | (own_a & pa_oe)  | (own_b & pb_oe);
  end

endmodule

// File: rtl/pinmux_in_steer.sv
module pinmux_in_steer #(
  parameter int NPIN = 32
) (
  input  logic [NPIN-1:0] own_g,
  input  logic [NPIN-1:0] own_a,
  input  logic [NPIN-1:0] own_b,
  input  logic [NPIN-1:0] pad_oe,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] gpio_in,
  output logic [NPIN-1:0] pa_in,
  output logic [NPIN-1:0] pb_in
);
  logic [NPIN-1:0] heard;

  // A driven pad does not echo its level back to any listener
  always_comb begin
    heard   = pad_in & ~pad_oe;
    gpio_in = heard & own_g;
    pa_in   = heard & own_a;
    pb_in   = heard & own_b;
  end

endmodule

// File: rtl/pinmux_stage.sv
module pinmux_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= '0;
      primed <= 1'b0;
    end else begin
      q      <= d;
      primed <= 1'b1;
    end
  end

  // R8: registered copy trails its input by exactly one edge
  p_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    primed |-> (q == $past(d)));

endmodule

// File: rtl/pin_mux.sv
module pin_mux #(
  parameter int NPIN    = 32,
  parameter bit REG_OUT = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] gpio_mode,
  input  logic [NPIN-1:0] sel_b,
  input  logic [NPIN-1:0] pad_in,
  input  logic [NPIN-1:0] gpio_out,
  input  logic [NPIN-1:0] gpio_oe,
  input  logic [NPIN-1:0] pa_out,
  input  logic [NPIN-1:0] pa_oe,
  input  logic [NPIN-1:0] pb_out,
  input  logic [NPIN-1:0] pb_oe,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] gpio_in,
  output logic [NPIN-1:0] pa_in,
  output logic [NPIN-1:0] pb_in
);
  import pinmux_pkg::*;

  localparam int BUS_W = OUT_GROUPS * NPIN;

  logic [NPIN-1:0] own_g, own_a, own_b;
  logic [NPIN-1:0] pad_out_c, pad_oe_c, gpio_in_c, pa_in_c, pb_in_c;
  logic [BUS_W-1:0] bus_c, bus_o;

  pinmux_owner_dec #(.NPIN(NPIN)) u_dec (
    .gpio_mode (gpio_mode),
    .sel_b     (sel_b),
    .own_g     (own_g),
    .own_a     (own_a),
    .own_b     (own_b)
  );

  pinmux_out_sel #(.NPIN(NPIN)) u_out (
    .own_g    (own_g),
    .own_a    (own_a),
    .own_b    (own_b),
    .gpio_out (gpio_out),
    .gpio_oe  (gpio_oe),
    .pa_out   (pa_out),
    .pa_oe    (pa_oe),
    .pb_out   (pb_out),
    .pb_oe    (pb_oe),
    .pad_out  (pad_out_c),
    .pad_oe   (pad_oe_c)
  );

  pinmux_in_steer #(.NPIN(NPIN)) u_in (
    .own_g   (own_g),
    .own_a   (own_a),
    .own_b   (own_b),
    .pad_oe  (pad_oe_c),
    .pad_in  (pad_in),
    .gpio_in (gpio_in_c),
    .pa_in   (pa_in_c),
    .pb_in   (pb_in_c)
  );

  assign bus_c = {pad_out_c, pad_oe_c, gpio_in_c, pa_in_c, pb_in_c};

  if (REG_OUT) begin : g_reg
    pinmux_stage #(.W(BUS_W)) u_stage (
      .clk (clk),
      .rst (rst),
      .d   (bus_c),
      .q   (bus_o)
    );
  end else begin : g_comb
    assign bus_o = bus_c;
  end

  assign {pad_out, pad_oe, gpio_in, pa_in, pb_in} = bus_o;

  // R1: exactly one owner per pin
  for (genvar i = 0; i < NPIN; i++) begin : g_chk
    p_one_owner_r1: assert property (@(posedge clk) disable iff (rst)
      $onehot({own_g[i], own_a[i], own_b[i]}));
  end

  // R4: GPIO pins never leak the pad to a peripheral
  p_gpio_isolates_r4: assert property (@(posedge clk) disable iff (rst)
    ((pa_in_c | pb_in_c) & gpio_mode) == '0);

  // R5: a driven pad feeds no listener
  p_driven_silent_r5: assert property (@(posedge clk) disable iff (rst)
    ((pa_in_c | pb_in_c | gpio_in_c) & pad_oe_c) == '0);

  // R6: the peripheral not chosen hears nothing
  p_unchosen_zero_r6: assert property (@(posedge clk) disable iff (rst)
    ((pa_in_c & sel_b) | (pb_in_c & ~sel_b)) == '0);

  // R7: GPIO listener only in GPIO mode
  p_gpio_in_mode_r7: assert property (@(posedge clk) disable iff (rst)
    (gpio_in_c & ~gpio_mode) == '0);

endmodule

// File: tb/pin_mux_tb.sv
`timescale 1ns/1ps
module pin_mux_tb;
  localparam int N = 32;

  typedef struct {
    logic [N-1:0] md, sl, pi, go, goe, ao, aoe, bo, boe;
    logic [N-1:0] e_pout, e_poe, e_gin, e_ain, e_bin;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] md, sl, pi, go, goe, ao, aoe, bo, boe;
  logic [N-1:0] c_pout, c_poe, c_gin, c_ain, c_bin;
  logic [N-1:0] r_pout, r_poe, r_gin, r_ain, r_bin;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  item_t q[$];

  always #2.5 clk = ~clk;

  pin_mux #(.NPIN(N), .REG_OUT(1'b0)) u_dut (
    .clk(clk), .rst(rst), .gpio_mode(md), .sel_b(sl), .pad_in(pi),
    .gpio_out(go), .gpio_oe(goe), .pa_out(ao), .pa_oe(aoe),
    .pb_out(bo), .pb_oe(boe), .pad_out(c_pout), .pad_oe(c_poe),
    .gpio_in(c_gin), .pa_in(c_ain), .pb_in(c_bin));

  pin_mux #(.NPIN(N), .REG_OUT(1'b1)) u_dut_reg (
    .clk(clk), .rst(rst), .gpio_mode(md), .sel_b(sl), .pad_in(pi),
    .gpio_out(go), .gpio_oe(goe), .pa_out(ao), .pa_oe(aoe),
    .pb_out(bo), .pb_oe(boe), .pad_out(r_pout), .pad_oe(r_poe),
    .gpio_in(r_gin), .pa_in(r_ain), .pb_in(r_bin));

  task automatic chk(input string tag, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Reference model written per pin from the requirements
  task automatic model(inout item_t it);
    for (int i = 0; i < N; i++) begin
      logic o, e;
      if (it.md[i]) begin
        o = it.go[i]; e = it.goe[i];
      end else if (it.sl[i]) begin
        o = it.bo[i]; e = it.boe[i];
      end else begin
        o = it.ao[i]; e = it.aoe[i];
      end
      it.e_pout[i] = o;
      it.e_poe[i]  = e;
      it.e_gin[i]  = (!e && it.md[i]) ? it.pi[i] : 1'b0;
      it.e_ain[i]  = (!e && !it.md[i] && !it.sl[i]) ? it.pi[i] : 1'b0;
      it.e_bin[i]  = (!e && !it.md[i] && it.sl[i]) ? it.pi[i] : 1'b0;
    end
  endtask

  // Driver: one vector per cycle, applied after the edge
  task automatic drive(input string tag,
      input logic [N-1:0] a_md, input logic [N-1:0] a_sl, input logic [N-1:0] a_pi,
      input logic [N-1:0] a_go, input logic [N-1:0] a_goe,
      input logic [N-1:0] a_ao, input logic [N-1:0] a_aoe,
      input logic [N-1:0] a_bo, input logic [N-1:0] a_boe);
    item_t it;
    @(posedge clk); #1;
    it.md = a_md; it.sl = a_sl; it.pi = a_pi; it.go = a_go; it.goe = a_goe;
    it.ao = a_ao; it.aoe = a_aoe; it.bo = a_bo; it.boe = a_boe; it.tag = tag;
    model(it);
    md = a_md; sl = a_sl; pi = a_pi; go = a_go; goe = a_goe;
    ao = a_ao; aoe = a_aoe; bo = a_bo; boe = a_boe;
    q.push_back(it);
  endtask

  // Monitor: combinational copy now, registered copy one cycle later (R8)
  initial begin
    item_t cur, prev;
    bit pv = 1'b0;
    forever begin
      @(negedge clk);
      if (pv) begin
        chk("R8", {prev.tag, " reg pad_out"}, r_pout, prev.e_pout);
        chk("R8", {prev.tag, " reg pad_oe"},  r_poe,  prev.e_poe);
        chk("R8", {prev.tag, " reg inputs"},  r_gin ^ r_ain ^ r_bin,
            prev.e_gin ^ prev.e_ain ^ prev.e_bin);
      end
      if (q.size() > 0) begin
        cur = q.pop_front();
        chk(cur.tag, "pad_out", c_pout, cur.e_pout);
        chk(cur.tag, "pad_oe",  c_poe,  cur.e_poe);
        chk(cur.tag, "gpio_in", c_gin,  cur.e_gin);
        chk(cur.tag, "pa_in",   c_ain,  cur.e_ain);
        chk(cur.tag, "pb_in",   c_bin,  cur.e_bin);
        prev = cur; pv = 1'b1;
      end else begin
        pv = 1'b0;
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  localparam logic [N-1:0] Z = '0;
  localparam logic [N-1:0] F = '1;

  initial begin
    md = F; sl = 32'hA5A5_5A5A; pi = F; go = F; goe = F;
    ao = F; aoe = F; bo = F; boe = F;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: registered copy is cleared while reset is high
    chk("R8", "reset pad_out", r_pout, Z);
    chk("R8", "reset pad_oe",  r_poe,  Z);
    chk("R8", "reset inputs",  r_gin | r_ain | r_bin, Z);
    @(posedge clk); #1;
    rst = 1'b0;
    md = Z; sl = Z; pi = Z; go = Z; goe = Z; ao = Z; aoe = Z; bo = Z; boe = Z;

    // R1 / R2: all pins on A, then all on B, pads listening
    drive("R1", Z, Z, 32'h1234_5678, F, F, 32'hCAFE_F00D, Z, 32'h0BAD_BEEF, F);
    drive("R2", Z, F, 32'h8765_4321, F, F, 32'hCAFE_F00D, F, 32'h0BAD_BEEF, Z);
    // R3: unchosen peripheral toggles wildly, chosen one steady
    drive("R3", Z, Z, Z, Z, Z, 32'h00FF_00FF, 32'hFFFF_0000, F, F);
    drive("R3", Z, Z, Z, Z, Z, 32'h00FF_00FF, 32'hFFFF_0000, Z, Z);
    drive("R3", Z, F, Z, Z, Z, F, F, 32'h0F0F_0F0F, 32'h3333_CCCC);
    drive("R3", Z, F, Z, Z, Z, Z, Z, 32'h0F0F_0F0F, 32'h3333_CCCC);
    // R4: all GPIO, peripherals active but ignored, pad high
    drive("R4", F, 32'h5555_AAAA, F, 32'hDEAD_BEEF, 32'h0000_FFFF, F, Z, F, Z);
    drive("R4", F, Z, F, 32'hDEAD_BEEF, 32'h0000_FFFF, Z, F, Z, F);
    // R5: driven pads feed nobody, in all three ownerships
    drive("R5", 32'h0000_00FF, 32'h00FF_FF00, F, F, F, F, F, F, F);
    // R6: unchosen peripheral input is 0 with pad high everywhere
    drive("R6", Z, 32'hF0F0_F0F0, F, Z, Z, Z, Z, Z, Z);
    // R7: GPIO listener on half the pins, others in peripheral mode
    drive("R7", 32'hFFFF_0000, 32'h00FF_00FF, 32'h3C3C_3C3C, Z, 32'hF000_0000, Z, Z, Z, Z);
    // R8: select flips every cycle, same-cycle effect on combinational copy
    for (int k = 0; k < 6; k++)
      drive("R8", Z, (k % 2 == 0) ? Z : F, 32'h9999_6666, Z, Z, 32'hAAAA_AAAA, Z,
            32'h5555_5555, Z);
    // R9: walking GPIO-mode bit in an otherwise peripheral-owned word
    for (int k = 0; k < N; k++)
      drive("R9", 32'h1 << k, 32'h6969_9696, F, 32'hFFFF_FFFF, 32'h1 << k,
            Z, Z, Z, Z);
    // R9: mixed random patterns
    for (int k = 0; k < 60; k++)
      drive("R9", $urandom, $urandom, $urandom, $urandom, $urandom,
            $urandom, $urandom, $urandom, $urandom);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule